// File: doc/BRIEF.md
# Memory-Mapped Data Memory Decoder

This block is the data side of a small 16-bit processor's memory system. A single 15-bit word address reaches one flat space, and the block steers each access to one of three targets: a general-purpose RAM, a frame buffer that holds a monochrome image, or a read-only key-code register. The processor port has a write strobe, write data and a read-data output. Reads are combinational on the current address. Writes take effect on the rising clock edge while the strobe is high.

A second, read-only port is meant for a display scanner. It takes a pixel row and column and returns that single pixel from the frame buffer, independently of whatever the processor port is addressing. The key-code register samples an external key-code input on every clock. Any address above the key-code register is reported as invalid.

The general RAM region spans 16K addresses. The storage behind it is a parameter. With the default of 4096 words, the region's upper address bits fold onto the same storage.

Top module: `mmio_data_mem`

## Requirements
- R1: When `memLoad` is high at a rising edge and `memAddr` is in 0..16383, `memWrData` is stored in the general RAM. A later read of that address on `memRdData` returns it, combinationally and with no added cycle.
- R2: General RAM storage holds 2^RAM_BACK_AW words (4096 by default). Within 0..16383, addresses that differ only above bit RAM_BACK_AW-1 reach the same word.
- R3: Addresses 16384..24575 reach the frame buffer at word offset (address - 16384), for both writes and reads.
- R4: A read at address 24576 returns the key code that `keyCode` carried at the most recent rising edge.
- R5: A write to address 24576 or above changes no stored state. The key-code register, the RAM and the frame buffer all keep their contents.
- R6: For any address above 24576, `memRdData` is 0 and `badAccess` is 1 in the same cycle. For every address up to 24576, `badAccess` is 0.
- R7: With `memLoad` low, a clock edge changes nothing at any address.
- R8: `pixBit` is bit (pixCol mod 16) of frame-buffer word 32*pixRow + pixCol/16, where bit 0 is the least significant. It is combinational and does not depend on `memAddr`.
- R9: A synchronous reset (`rst` high at a rising edge) clears the key-code register to 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | input | 15 | Word address of the processor port |
| memWrData | input | 16 | Data to store |
| memLoad | input | 1 | Write strobe, sampled at the rising edge |
| memRdData | output | 16 | Combinational read data for memAddr |
| badAccess | output | 1 | High while memAddr is above the key-code address |
| keyCode | input | 16 | Code of the key currently held, 0 for none |
| pixRow | input | 8 | Pixel row for the scanner port |
| pixCol | input | 9 | Pixel column for the scanner port |
| pixBit | output | 1 | Pixel value at (pixRow, pixCol) |

## Verification
Results arrive on two timings. Read data, the invalid flag and the pixel bit respond combinationally, in the same cycle as their address inputs. A write, or a new key code, becomes visible only after the next rising edge. The bench changes inputs on the falling edge and samples 2 ns later for combinational results. For anything that has to pass through a register, it samples again after the following rising edge. The key-code check reads the old code before that edge and the new one after it, which pins the latency at exactly one edge.

// File: rtl/mmio_mem_pkg.sv
package mmio_mem_pkg;

  // Per-access strobes produced by the address decoder
  typedef struct packed {
    logic pickRam;
    logic pickFb;
    logic pickKey;
    logic pickBad;
    logic wrRam;
    logic wrFb;
  } memStrobe_t;

endpackage

// File: rtl/mmio_mem_ctrl.sv
module mmio_mem_ctrl
  import mmio_mem_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memLoad,
  output memStrobe_t        strb
);
  // The RAM takes the lower half of the space and the frame buffer the next quarter.
  // The key register is the single word right after the frame buffer.
  localparam logic [ADDR_W-1:0] FB_BASE  = ADDR_W'(1 << (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'((1 << (ADDR_W - 1)) + (1 << (ADDR_W - 2)));

  always_comb begin
    strb = '0;
    if (memAddr < FB_BASE)       strb.pickRam = 1'b1;
    else if (memAddr < KEY_ADDR) strb.pickFb  = 1'b1;
    else if (memAddr == KEY_ADDR) strb.pickKey = 1'b1;
    else                          strb.pickBad = 1'b1;
    // The key register and invalid addresses never accept a write
    strb.wrRam = strb.pickRam & memLoad;
    strb.wrFb  = strb.pickFb & memLoad;
  end
endmodule

// File: rtl/mmio_mem_dpath.sv
module mmio_mem_dpath
  import mmio_mem_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 16,
  parameter int RAM_BACK_AW = 12,
  parameter int PIX_ROW_W   = 8,
  parameter int PIX_COL_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [DATA_W-1:0]    memWrData,
  input  memStrobe_t           strb,
  input  logic [DATA_W-1:0]    keyCode,
  input  logic [PIX_ROW_W-1:0] pixRow,
  input  logic [PIX_COL_W-1:0] pixCol,
  output logic [DATA_W-1:0]    memRdData,
  output logic                 pixBit
);
  localparam int FB_AW    = ADDR_W - 2;
  localparam int BIT_AW   = $clog2(DATA_W);
  localparam int RAM_DEPTH = 1 << RAM_BACK_AW;
  localparam int FB_DEPTH  = 1 << FB_AW;

  logic [DATA_W-1:0] ramMem [RAM_DEPTH];
  logic [DATA_W-1:0] fbMem  [FB_DEPTH];
  logic [DATA_W-1:0] keyReg;

  logic [RAM_BACK_AW-1:0] ramIdx;
  logic [FB_AW-1:0]       fbIdx;
  logic [FB_AW-1:0]       pixWordIdx;
  logic [DATA_W-1:0]      pixWord;

  assign ramIdx = memAddr[RAM_BACK_AW-1:0];
  // The frame-buffer base is a power of two, so the offset is the low address bits
  assign fbIdx  = memAddr[FB_AW-1:0];

  always_ff @(posedge clk) begin
    if (strb.wrRam) ramMem[ramIdx] <= memWrData;
  end

  always_ff @(posedge clk) begin
    if (strb.wrFb) fbMem[fbIdx] <= memWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) keyReg <= '0;
    else     keyReg <= keyCode;
  end

  always_comb begin
    memRdData = '0;
    if (strb.pickRam)      memRdData = ramMem[ramIdx];
    else if (strb.pickFb)  memRdData = fbMem[fbIdx];
    else if (strb.pickKey) memRdData = keyReg;
  end

  // Each image row is a run of words, and the upper column bits pick the word within it
  assign pixWordIdx = FB_AW'({pixRow, pixCol[PIX_COL_W-1:BIT_AW]});
  assign pixWord    = fbMem[pixWordIdx];
  assign pixBit     = pixWord[pixCol[BIT_AW-1:0]];
endmodule

// File: rtl/mmio_data_mem.sv
module mmio_data_mem
  import mmio_mem_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 16,
  parameter int RAM_BACK_AW = 12,
  parameter int PIX_ROW_W   = 8,
  parameter int PIX_COL_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [DATA_W-1:0]    memWrData,
  input  logic                 memLoad,
  output logic [DATA_W-1:0]    memRdData,
  output logic                 badAccess,
  input  logic [DATA_W-1:0]    keyCode,
  input  logic [PIX_ROW_W-1:0] pixRow,
  input  logic [PIX_COL_W-1:0] pixCol,
  output logic                 pixBit
);
  memStrobe_t strb;

  mmio_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .memAddr(memAddr),
    .memLoad(memLoad),
    .strb   (strb)
  );

  mmio_mem_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BACK_AW(RAM_BACK_AW),
    .PIX_ROW_W(PIX_ROW_W), .PIX_COL_W(PIX_COL_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .strb     (strb),
    .keyCode  (keyCode),
    .pixRow   (pixRow),
    .pixCol   (pixCol),
    .memRdData(memRdData),
    .pixBit   (pixBit)
  );

  assign badAccess = strb.pickBad;
endmodule

// File: rtl/mmio_data_mem_chk.sv
module mmio_data_mem_chk
  import mmio_mem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              memLoad,
  input logic [DATA_W-1:0] memRdData,
  input logic              badAccess,
  input logic [DATA_W-1:0] keyCode,
  input memStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] FB_BASE  = ADDR_W'(1 << (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'((1 << (ADDR_W - 1)) + (1 << (ADDR_W - 2)));

  // R6: invalid region reads zero and is flagged
  assert_bad_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (memAddr > KEY_ADDR) |-> (badAccess && memRdData == '0));

  // R6: flag stays low inside the mapped space
  assert_no_flag_in_map_R6: assert property (@(posedge clk) disable iff (rst)
    (memAddr <= KEY_ADDR) |-> !badAccess);

  // R1: a RAM write is readable on the next cycle at the same address
  assert_ram_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    (memLoad && memAddr < FB_BASE) |=> (!$stable(memAddr) || memRdData == $past(memWrData)));

  // R3: a frame-buffer write is readable on the next cycle at the same address
  assert_fb_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (memLoad && memAddr >= FB_BASE && memAddr < KEY_ADDR)
      |=> (!$stable(memAddr) || memRdData == $past(memWrData)));

  // R4: key register read shows the code sampled at the previous edge
  assert_key_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && memAddr == KEY_ADDR) |-> memRdData == $past(keyCode));

  // R5: the decoder grants at most one write path per access
  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrRam, strb.wrFb}) && $countones({strb.pickRam, strb.pickFb, strb.pickKey, strb.pickBad}) == 1);
endmodule

bind mmio_data_mem mmio_data_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memWrData(memWrData), .memLoad(memLoad),
  .memRdData(memRdData), .badAccess(badAccess), .keyCode(keyCode), .strb(strb)
);

// File: tb/mmio_data_mem_bench.sv
`timescale 1ns/1ps
module mmio_data_mem_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [14:0] memAddr;
  logic [15:0] memWrData;
  logic        memLoad;
  logic [15:0] memRdData;
  logic        badAccess;
  logic [15:0] keyCode;
  logic [7:0]  pixRow;
  logic [8:0]  pixCol;
  logic        pixBit;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mmio_data_mem u_mmio_data_mem (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWrData(memWrData), .memLoad(memLoad),
    .memRdData(memRdData), .badAccess(badAccess), .keyCode(keyCode),
    .pixRow(pixRow), .pixCol(pixCol), .pixBit(pixBit)
  );

  typedef struct packed {
    logic        wr;
    logic [14:0] addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic        bad;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 15'd0,     16'h1111, 16'h0000, 1'b0, 4'd1}, // R1 write low end
    '{1'b1, 15'd16383, 16'h2222, 16'h0000, 1'b0, 4'd1}, // R1 write top of RAM
    '{1'b0, 15'd0,     16'h0000, 16'h1111, 1'b0, 4'd1}, // R1
    '{1'b0, 15'd16383, 16'h0000, 16'h2222, 1'b0, 4'd1}, // R1
    '{1'b1, 15'd100,   16'hABCD, 16'h0000, 1'b0, 4'd2}, // R2
    '{1'b0, 15'd4196,  16'h0000, 16'hABCD, 1'b0, 4'd2}, // R2 fold of 100
    '{1'b1, 15'd16384, 16'h1234, 16'h0000, 1'b0, 4'd3}, // R3 first FB word
    '{1'b1, 15'd24575, 16'h8001, 16'h0000, 1'b0, 4'd3}, // R3 last FB word
    '{1'b1, 15'd16385, 16'h5555, 16'h0000, 1'b0, 4'd3}, // R3
    '{1'b0, 15'd16384, 16'h0000, 16'h1234, 1'b0, 4'd3}, // R3
    '{1'b0, 15'd24575, 16'h0000, 16'h8001, 1'b0, 4'd3}, // R3
    '{1'b0, 15'd24576, 16'h0000, 16'h0041, 1'b0, 4'd4}, // R4 key code
    '{1'b1, 15'd24576, 16'hFFFF, 16'h0000, 1'b0, 4'd5}, // R5 write key
    '{1'b0, 15'd24576, 16'h0000, 16'h0041, 1'b0, 4'd5}, // R5
    '{1'b1, 15'd24577, 16'hDEAD, 16'h0000, 1'b1, 4'd5}, // R5 write invalid
    '{1'b0, 15'd24577, 16'h0000, 16'h0000, 1'b1, 4'd6}, // R6
    '{1'b0, 15'd32767, 16'h0000, 16'h0000, 1'b1, 4'd6}, // R6 top address
    '{1'b0, 15'd16385, 16'h0000, 16'h5555, 1'b0, 4'd5}, // R5 FB untouched
    '{1'b0, 15'd1,     16'h0000, 16'h0000, 1'b0, 4'd5}, // R5 RAM word 1 never written -> 0 after clear below
    '{1'b0, 15'd0,     16'h0000, 16'h1111, 1'b0, 4'd5}  // R5 RAM untouched
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; memAddr = 15'd24576; memWrData = '0; memLoad = 1'b0;
    keyCode = 16'h0041; pixRow = '0; pixCol = '0;
    tick(); tick(); tick();
    #2;
    // R9 and R4: the key register reads 0 while in reset
    check("R9 key cleared by reset", memRdData, 16'h0000);
    rst = 1'b0;
    // clear RAM word 1 so the later untouched check has a known value
    memAddr = 15'd1; memWrData = 16'h0000; memLoad = 1'b1;
    tick();
    memLoad = 1'b0;

    for (int i = 0; i < NV; i++) begin
      memAddr = VECS[i].addr; memWrData = VECS[i].data; memLoad = VECS[i].wr;
      #2;
      if (!VECS[i].wr) begin
        check($sformatf("R%0d read %0d", VECS[i].req, VECS[i].addr), memRdData, VECS[i].exp);
        check($sformatf("R%0d flag %0d", VECS[i].req, VECS[i].addr), {15'd0, badAccess}, {15'd0, VECS[i].bad});
      end
      tick();
      memLoad = 1'b0;
    end

    // R7: load low leaves the word alone
    memAddr = 15'd0; memWrData = 16'h9999; memLoad = 1'b0;
    tick(); #2;
    check("R7 no write without load", memRdData, 16'h1111);

    // R4: new key code appears only after the next edge
    memAddr = 15'd24576; keyCode = 16'h0020;
    #2;
    check("R4 old code before edge", memRdData, 16'h0041);
    tick(); #2;
    check("R4 new code after edge", memRdData, 16'h0020);

    // R8: pixel port, row 3 word 5 holds bit 2 set
    memAddr = 15'd16485; memWrData = 16'h0004; memLoad = 1'b1;
    tick();
    memLoad = 1'b0; memAddr = 15'd0;
    pixRow = 8'd3; pixCol = 9'd82; #2;
    check("R8 pixel (3,82)", {15'd0, pixBit}, 16'd1);
    pixCol = 9'd81; #2;
    check("R8 pixel (3,81)", {15'd0, pixBit}, 16'd0);
    pixRow = 8'd255; pixCol = 9'd511; memAddr = 15'd24577; #2;
    check("R8 pixel (255,511)", {15'd0, pixBit}, 16'd1);
    pixCol = 9'd496; #2;
    check("R8 pixel (255,496)", {15'd0, pixBit}, 16'd1);
    pixCol = 9'd497; #2;
    check("R8 pixel (255,497)", {15'd0, pixBit}, 16'd0);
    pixRow = 8'd0; pixCol = 9'd2; #2;
    check("R8 pixel (0,2)", {15'd0, pixBit}, 16'd1);

    // R9: a later reset clears the key register but keeps memory
    memAddr = 15'd24576; rst = 1'b1;
    tick(); #2;
    check("R9 key cleared mid-run", memRdData, 16'h0000);
    rst = 1'b0;
    memAddr = 15'd0; #2;
    check("R9 RAM kept over reset", memRdData, 16'h1111);
    memAddr = 15'd16384; #2;
    check("R9 FB kept over reset", memRdData, 16'h1234);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule